// File: doc/BRIEF.md
# Serial USB Checksum Engine (5-bit and 16-bit)

This block computes the cyclic checksums that protect full-speed USB packet fields, one bit at a time. A single shift register serves both checksum widths: the short 5-bit code that guards the 11-bit address/endpoint or frame-number field of token packets, and the 16-bit code that guards data payloads. A width input picks the variant. The surrounding packet logic decides where the protected field lies. It raises a run input for the length of that field and pulses a strobe once per unstuffed bit.

On the transmit side, the controller first lets the payload bits flow through in accumulate mode. It then raises an emit input for exactly the checksum length, and the engine shifts out the complemented remainder, most significant bit first, one bit per strobe. The emitted bit can therefore replace the zero-filled checksum field in the outgoing stream. On the receive side, the payload and the received checksum both pass through the engine. When the line reports single-ended zero (end of packet), the engine stops updating and latches a pass/fail flag. That flag holds until the next packet begins.

Top module: `usb_crc_serial`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `crc_ok` and `crc_bit_out` are 0.
- R2: While `crc_run` is 0, the register is held at all ones. Strobes and data bits given while `crc_run` is 0 have no effect on the checksum of the next packet.
- R3: With `wide_sel`=0, each strobed bit is XORed with register bit 4. The register shifts left with a 0 inserted, and when the XOR result was 1 the register is XORed with 5'b00101. For the field 00001000111, fed left bit first, the emitted checksum is 10100.
- R4: With `wide_sel`=1, the same update uses register bit 15 and the polynomial 16'h8005 (x^16+x^15+x^2+1).
- R5: While `emit_sel`=1, each strobe puts the inverse of the register's top bit on `crc_bit_out` at that clock edge and shifts the register left. The complemented remainder therefore appears most significant bit first. `crc_bit_out` changes only on strobes with `emit_sel`=1.
- R6: A cycle with `bit_stb`=0 changes neither the register nor `crc_bit_out`.
- R7: With `rx_mode`=1 and `crc_run`=1, a cycle with `se0`=1 stops all further updates and emission until `crc_run` falls. At that edge, `crc_ok` is set to 1 if the remainder equals 5'b01100 (short) or 16'h800D (long).
- R8: If the received field or checksum is corrupted, `crc_ok` is 0 after the `se0` cycle.
- R9: `crc_ok` holds its value while `crc_run` is 0. It is cleared at the first edge where `crc_run` is seen at 1 after being 0 (packet start).
- R10: With `rx_mode`=0, `se0` has no effect: accumulation continues and the emitted checksum is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_run | input | 1 | High while the protected field and its checksum are passing. Low presets the register |
| bit_stb | input | 1 | One-cycle strobe per data bit |
| bit_in | input | 1 | Serial data bit, protected-field order |
| wide_sel | input | 1 | 0 selects the 5-bit checksum, 1 selects the 16-bit checksum |
| rx_mode | input | 1 | 1 when receiving, which enables the end-of-packet halt |
| se0 | input | 1 | Line single-ended-zero indication |
| emit_sel | input | 1 | 1 shifts out the complemented remainder instead of accumulating |
| crc_bit_out | output | 1 | Registered emitted checksum bit |
| crc_ok | output | 1 | Registered receive check result, held until the next packet |

## Verification
The bench builds the engine with its default widths of 5 and 16 bits and the standard polynomials and residues. This lets it compare emitted checksums against hand-known values, such as the 11-bit example, and against a bench-side serial model for 16-bit payloads. With these defaults, whole received packets, including the appended complemented checksum, fit in 32 stimulus bits. The bench can therefore reach the residue comparison for both widths, the corrupted-bit case, the post-halt freeze and the strobe gaps in the middle of emission.

// File: rtl/usb_crc_pkg.sv
package usb_crc_pkg;
  localparam int unsigned SHORT_W = 5;
  localparam int unsigned LONG_W  = 16;

  localparam logic [SHORT_W-1:0] SHORT_POLY  = 5'h05;
  localparam logic [LONG_W-1:0]  LONG_POLY   = 16'h8005;
  localparam logic [SHORT_W-1:0] SHORT_RESID = 5'h0C;
  localparam logic [LONG_W-1:0]  LONG_RESID  = 16'h800D;

  typedef enum logic {
    CRC_SHORT = 1'b0,
    CRC_LONG  = 1'b1
  } crc_kind_e;

  function automatic logic [31:0] low_ones(input int unsigned w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/crc_step_unit.sv
module crc_step_unit #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned SW    = 5,
  parameter int unsigned LW    = 16,
  parameter logic [SW-1:0] SPOLY = 5'h05,
  parameter logic [LW-1:0] LPOLY = 16'h8005
) (
  input  logic [REG_W-1:0] cur,
  input  logic             wide,
  input  logic             din,
  input  logic             emit,
  output logic [REG_W-1:0] nxt,
  output logic             top
);
  localparam logic [REG_W-1:0] SMASK = REG_W'(usb_crc_pkg::low_ones(SW));
  localparam logic [REG_W-1:0] LMASK = REG_W'(usb_crc_pkg::low_ones(LW));
  localparam logic [REG_W-1:0] SPX   = REG_W'(SPOLY);
  localparam logic [REG_W-1:0] LPX   = REG_W'(LPOLY);

  logic [REG_W-1:0] mask;
  logic [REG_W-1:0] poly;
  logic [REG_W-1:0] shifted;
  logic             fb;

  always_comb begin
    top     = wide ? cur[LW-1] : cur[SW-1];
    mask    = wide ? LMASK : SMASK;
    poly    = wide ? LPX : SPX;
    shifted = (cur << 1) & mask;
    fb      = din ^ top;
    if (!emit && fb) nxt = shifted ^ poly;
    else             nxt = shifted;
  end
endmodule

// File: rtl/crc_residue_cmp.sv
module crc_residue_cmp #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned SW    = 5,
  parameter int unsigned LW    = 16,
  parameter logic [SW-1:0] SRES = 5'h0C,
  parameter logic [LW-1:0] LRES = 16'h800D
) (
  input  logic [REG_W-1:0] cur,
  input  logic             wide,
  output logic             match
);
  always_comb begin
    if (wide) match = (cur[LW-1:0] == LRES);
    else      match = (cur[SW-1:0] == SRES);
  end
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic stb,
  input  logic rx_mode,
  input  logic se0,
  input  logic match,
  output logic advance,
  output logic ok
);
  logic run_d;
  logic halted;
  logic start;
  logic halt_now;

  always_comb begin
    start    = run & ~run_d;
    halt_now = run & rx_mode & se0 & ~halted;
    advance  = run & stb & ~halted & ~halt_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d  <= 1'b0;
      halted <= 1'b0;
      ok     <= 1'b0;
    end else begin
      run_d <= run;
      if (!run)          halted <= 1'b0;
      else if (halt_now) halted <= 1'b1;
      if (halt_now)      ok <= match;
      else if (start)    ok <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_crc_serial.sv
module usb_crc_serial #(
  parameter int unsigned SW = usb_crc_pkg::SHORT_W,
  parameter int unsigned LW = usb_crc_pkg::LONG_W,
  parameter logic [SW-1:0] SPOLY = usb_crc_pkg::SHORT_POLY,
  parameter logic [LW-1:0] LPOLY = usb_crc_pkg::LONG_POLY,
  parameter logic [SW-1:0] SRES  = usb_crc_pkg::SHORT_RESID,
  parameter logic [LW-1:0] LRES  = usb_crc_pkg::LONG_RESID
) (
  input  logic clk,
  input  logic rst,
  input  logic crc_run,
  input  logic bit_stb,
  input  logic bit_in,
  input  logic wide_sel,
  input  logic rx_mode,
  input  logic se0,
  input  logic emit_sel,
  output logic crc_bit_out,
  output logic crc_ok
);
  localparam int unsigned REG_W = (LW > SW) ? LW : SW;

  logic [REG_W-1:0] crc_q;
  logic [REG_W-1:0] crc_nxt;
  logic             top_bit;
  logic             match;
  logic             advance;

  crc_step_unit #(
    .REG_W(REG_W), .SW(SW), .LW(LW), .SPOLY(SPOLY), .LPOLY(LPOLY)
  ) u_step (
    .cur(crc_q), .wide(wide_sel), .din(bit_in), .emit(emit_sel),
    .nxt(crc_nxt), .top(top_bit)
  );

  crc_residue_cmp #(
    .REG_W(REG_W), .SW(SW), .LW(LW), .SRES(SRES), .LRES(LRES)
  ) u_cmp (
    .cur(crc_q), .wide(wide_sel), .match(match)
  );

  crc_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .run(crc_run), .stb(bit_stb),
    .rx_mode(rx_mode), .se0(se0), .match(match),
    .advance(advance), .ok(crc_ok)
  );

  // Register: preset while idle (R2), advance on accepted strobes (R3, R4)
  always_ff @(posedge clk) begin
    if (rst || !crc_run) crc_q <= '1;
    else if (advance)    crc_q <= crc_nxt;
  end

  // Emitted bit: complement of the top bit, one per strobe (R5)
  always_ff @(posedge clk) begin
    if (rst)                       crc_bit_out <= 1'b0;
    else if (advance && emit_sel)  crc_bit_out <= ~top_bit;
  end
endmodule

// File: rtl/crc_engine_checker.sv
module crc_engine_checker (
  input logic clk,
  input logic rst,
  input logic crc_run,
  input logic bit_stb,
  input logic bit_in,
  input logic wide_sel,
  input logic rx_mode,
  input logic se0,
  input logic emit_sel,
  input logic crc_bit_out,
  input logic crc_ok
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!crc_ok && !crc_bit_out)); // R1

  AST_NO_STB_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(crc_bit_out)); // R6

  AST_OUT_ONLY_IN_EMIT: assert property (@(posedge clk) disable iff (rst)
    !emit_sel |=> $stable(crc_bit_out)); // R5

  AST_OK_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !crc_run |=> $stable(crc_ok)); // R9

  AST_OK_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(crc_run) && !(rx_mode && se0)) |=> !crc_ok); // R9
endmodule

bind usb_crc_serial crc_engine_checker u_chk (.*);

// File: tb/tb_usb_crc_serial.sv
module tb_usb_crc_serial;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crc_run = 1'b0, bit_stb = 1'b0, bit_in = 1'b0, wide_sel = 1'b0;
  logic rx_mode = 1'b0, se0 = 1'b0, emit_sel = 1'b0;
  logic crc_bit_out, crc_ok;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  usb_crc_serial dut (
    .clk(clk), .rst(rst), .crc_run(crc_run), .bit_stb(bit_stb), .bit_in(bit_in),
    .wide_sel(wide_sel), .rx_mode(rx_mode), .se0(se0), .emit_sel(emit_sel),
    .crc_bit_out(crc_bit_out), .crc_ok(crc_ok)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference checksum from the requirement text: MSB-first, preset ones, inverted
  function automatic logic [15:0] ref_crc(input logic wide, input logic [31:0] bits, input int n);
    int w;
    logic [15:0] r, mask, poly;
    logic fb;
    w    = wide ? 16 : 5;
    mask = wide ? 16'hFFFF : 16'h001F;
    poly = wide ? 16'h8005 : 16'h0005;
    r    = mask;
    for (int i = n - 1; i >= 0; i--) begin
      fb = bits[i] ^ r[w-1];
      r  = (r << 1) & mask;
      if (fb) r = r ^ poly;
    end
    return (~r) & mask;
  endfunction

  task automatic cyc(input logic r, input logic s, input logic b, input logic e, input logic z);
    crc_run = r; bit_stb = s; bit_in = b; emit_sel = e; se0 = z;
    @(negedge clk);
  endtask

  task automatic feed(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) cyc(1'b1, 1'b1, bits[i], 1'b0, 1'b0);
  endtask

  task automatic emit(input int n, output logic [15:0] res);
    res = '0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      res = {res[14:0], crc_bit_out};
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ok in reset", {15'd0, crc_ok}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ok after reset", {15'd0, crc_ok}, 16'd0);
    chk("R1 out after reset", {15'd0, crc_bit_out}, 16'd0);
  endtask

  task automatic t_crc5_example;
    logic [15:0] got;
    rx_mode = 1'b0; wide_sel = 1'b0;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R2 idle strobes
    feed(32'b00001000111, 11);
    emit(5, got);
    chk("R3 example checksum", got, 16'b10100);
    chk("R2 idle strobes ignored", got, ref_crc(1'b0, 32'b00001000111, 11));
    idle(2);
  endtask

  task automatic t_crc16_tx;
    logic [15:0] got;
    rx_mode = 1'b0; wide_sel = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    feed(32'hA53C, 16);
    emit(16, got);
    chk("R4 16-bit checksum A53C", got, ref_crc(1'b1, 32'hA53C, 16));
    idle(1);
    feed(32'h00C3_5A01, 32);
    emit(16, got);
    chk("R4 16-bit checksum 32 bits", got, ref_crc(1'b1, 32'h00C3_5A01, 32));
    idle(2);
  endtask

  task automatic t_stb_gap;
    logic [15:0] got, expv;
    logic held;
    rx_mode = 1'b0; wide_sel = 1'b0;
    expv = ref_crc(1'b0, 32'h5A3, 11);
    feed(32'h5A3, 11);
    got = '0;
    for (int i = 0; i < 2; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      got = {got[14:0], crc_bit_out};
    end
    held = crc_bit_out;
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      chk("R6 output held without strobe", {15'd0, crc_bit_out}, {15'd0, held});
    end
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      got = {got[14:0], crc_bit_out};
    end
    chk("R5 emission across gaps", got, expv);
    idle(2);
  endtask

  task automatic t_rx(input logic wide, input logic [15:0] data, input int nd,
                      input logic corrupt, input string req);
    int w;
    logic [15:0] c;
    logic [31:0] pkt;
    logic held;
    w = wide ? 16 : 5;
    rx_mode = 1'b1; wide_sel = wide;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 ok cleared at packet start", {15'd0, crc_ok}, 16'd0);
    c = ref_crc(wide, {16'd0, data}, nd);
    pkt = ({16'd0, data} << w) | {16'd0, c};
    if (corrupt) pkt[3] = ~pkt[3];
    feed(pkt, nd + w);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(req, {15'd0, crc_ok}, {15'd0, ~corrupt});
    held = crc_bit_out;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R7 frozen after halt: out", {15'd0, crc_bit_out}, {15'd0, held});
    chk("R7 frozen after halt: ok", {15'd0, crc_ok}, {15'd0, ~corrupt});
    idle(3);
    chk("R9 ok held while idle", {15'd0, crc_ok}, {15'd0, ~corrupt});
  endtask

  task automatic t_tx_se0;
    logic [15:0] got;
    rx_mode = 1'b0; wide_sel = 1'b0;
    feed(32'b10110, 5);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    feed(32'b011101, 6);
    emit(5, got);
    chk("R10 se0 ignored in transmit", got, ref_crc(1'b0, 32'b10110_1_011101, 12));
    idle(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_crc5_example();
    t_crc16_tx();
    t_stb_gap();
    t_rx(1'b0, 16'h047, 11, 1'b0, "R7 short residue good");
    t_rx(1'b1, 16'hBEEF, 16, 1'b0, "R7 long residue good");
    t_rx(1'b1, 16'h1234, 16, 1'b1, "R8 long corrupted");
    t_rx(1'b0, 16'h2F1, 11, 1'b1, "R8 short corrupted");
    t_tx_se0();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule